// File: doc/BRIEF.md
# PMIC Register Bus Bridge

This block lets a host processor reach the registers of a power-management companion chip over a two-wire serial link (a clock line and a data line). The data line is brought out as an output value, an output enable and an input value, for a pad that is driven only while the enable is high. The host sees a small register bank plus a 4 KiB slave window. A store into the window is placed in an eight-entry write queue, and queued stores go out on the link in the order they arrived. A load from the companion chip is split into two steps. The host writes the wanted address into a read-command register, which launches the transfer. It then polls a read-data register until the busy flag drops. At that point the register holds the 16-bit value and an echo of the address that went out on the link, so software can confirm that the reply belongs to its request.

A pending read is held back until the write queue has drained, so it never overtakes an earlier store. Each serial frame is 29 bits long: a direction bit (1 = read, 0 = write), then a 12-bit register address, then 16 data bits, all sent MSB first. The bridge changes the data line while the link clock is low, and the slave samples it on the rising edge. During the 16 data bits of a read, the bridge releases the line and samples the slave's bits on its own rising edges. The link clock is either gated low while idle or left free-running, as a configuration bit selects.

Top module: `pmic_bridge`

## Requirements
- R1: A host write to the read-command register (byte offset 0x28) sets the busy flag, bit 31 of the read-data register (offset 0x2C), and the flag reads as 1 on the first cycle after that write.
- R2: A read is sent as a frame with direction bit 1 and the requested address. When the frame completes, busy clears, bits 15:0 of the read-data register hold the 16 bits the slave returned, and bits 30:16 hold the address sent on the link. In 12-bit mode that address equals the low 12 bits of the written command value.
- R3: A host write to byte offsets 0x8000 to 0x8FFF is queued and sent as a frame with direction bit 0, address = offset bits 11:0 and data = write-data bits 15:0. Queued writes go out in arrival order. Writes just outside that range produce no frame.
- R4: The queue status register (offset 0x30) shows empty in bit 10, full (8 entries) in bit 11 and the entry count in bits 3:0. Full and empty are never set together.
- R5: A window write that arrives while the queue is full is dropped and sets a sticky overflow flag in bit 12 of the status register. The flag stays set after the queue drains, and only a host write to offset 0x30 with bit 12 set clears it.
- R6: A read command issued while writes are queued is sent only after every write queued before it.
- R7: A read command written while busy is set is ignored: no second frame is sent and the echo reports the first address.
- R8: Bit 0 of the control register (offset 0x04) selects the address width. 0 gives 12-bit addressing. 1 gives 8-bit addressing, where address bits 11:8 are sent as zero on the link and echoed as zero.
- R9: With bit 30 of the configuration register (offset 0x20) set, the link clock toggles while the link is idle. With it clear, the link clock stays low while the link is idle.
- R10: After reset the read-data register reads 0, the status register reads 0x400 (empty, count 0), the link clock is low and the data-line enable is low.
- R11: The bridge changes its data-line output only while the link clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Single-cycle host write strobe |
| host_addr | input | 16 | Host byte address for reads and writes |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Combinational read data for host_addr |
| link_sck | output | 1 | Serial link clock |
| link_sda_o | output | 1 | Data line value driven by the bridge |
| link_sda_oe | output | 1 | Data line drive enable |
| link_sda_i | input | 1 | Data line value seen at the pad |

## Verification
The bench fills the queue with a quick burst and checks three things: full is set, the tenth store is dropped, and the overflow flag stays set until it is cleared. A design that kept the extra store would show a tenth frame on the link, and one that lost the flag would read 0x400 after the drain. It queues stores behind a read command and checks that the read frame comes last. A read that slipped ahead of them would show up as an out-of-order direction sequence in the slave model's log. It also sends a second command while busy, switches to 8-bit addressing, and watches the idle clock in both gating modes. A bridge that restarted the read, leaked address bits 11:8, or left the clock running would each produce a wrong frame count, echo or edge count.

// File: rtl/pmic_bridge_pkg.sv
// Shared constants for the PMIC register bus bridge.
// Assumes a 16-bit host byte address and 32-bit host data.
package pmic_bridge_pkg;
    localparam logic [15:0] OFS_CTRL0   = 16'h0004;
    localparam logic [15:0] OFS_CFG0    = 16'h0020;
    localparam logic [15:0] OFS_RDCMD   = 16'h0028;
    localparam logic [15:0] OFS_RDDATA  = 16'h002C;
    localparam logic [15:0] OFS_QSTAT   = 16'h0030;
    localparam logic [15:0] WIN_BASE    = 16'h8000;
    localparam int unsigned WIN_BYTES   = 4096;
    localparam logic [15:0] WIN_LAST    = WIN_BASE + 16'(WIN_BYTES - 1);

    localparam int BIT_BUSY    = 31;
    localparam int BIT_CLK_ON  = 30;
    localparam int BIT_OVF     = 12;
    localparam int BIT_FULL    = 11;
    localparam int BIT_EMPTY   = 10;
    localparam int NARROW_W    = 8;

    typedef enum logic {DIR_WRITE = 1'b0, DIR_READ = 1'b1} dir_e;
endpackage

// File: rtl/pmic_bridge_fifo.sv
// Write queue: stores {address, data} entries and returns them in arrival order.
// Assumes the caller never relies on push or pop doing anything when full or empty.
module pmic_bridge_fifo #(
    parameter int W     = 28,
    parameter int DEPTH = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic [W-1:0]                   wdata,
    input  logic                           pop,
    output logic [W-1:0]                   rdata,
    output logic                           full,
    output logic                           empty,
    output logic [$clog2(DEPTH+1)-1:0]     count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign count   = cnt_q;
    assign rdata   = mem[rd_ptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write: keep the incoming entry at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy upkeep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/pmic_bridge_link.sv
// Serial frame engine: shifts {direction, address, data} MSB first on a
// divided clock. Data changes while the clock is low, and the slave samples it on the rise.
// For reads it releases the line for the data bits and samples on its rises.
// Assumes start is held until ready accepts it.
module pmic_bridge_link #(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 16,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_on,
    input  logic              start,
    input  logic              is_read,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ready,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              sck,
    output logic              sda_o,
    output logic              sda_oe,
    input  logic              sda_i
);
    localparam int FRAME = 1 + ADDR_W + DATA_W;
    localparam int BW    = $clog2(FRAME);
    localparam int DW    = $clog2(HALF_DIV + 1);

    logic [DW-1:0]     div_q;
    logic              sck_q, active_q, rd_q, done_q;
    logic [BW-1:0]     bit_q;
    logic [FRAME-1:0]  sh_q;
    logic [DATA_W-1:0] rx_q;
    logic              running, tick, in_data;

    assign running = active_q || clk_on;
    assign tick    = running && (div_q == DW'(HALF_DIV - 1));
    assign in_data = rd_q && (bit_q >= BW'(1 + ADDR_W));
    assign ready   = !active_q && !sck_q && !tick;
    assign busy    = active_q;
    assign done    = done_q;
    assign rdata   = rx_q;
    assign sck     = sck_q;
    assign sda_o   = sh_q[FRAME-1];
    assign sda_oe  = active_q && !in_data;

    // Half-period divider, held at zero while the clock is gated.
    always_ff @(posedge clk) begin
        if (!rst_n || !running) div_q <= '0;
        else if (tick)          div_q <= '0;
        else                    div_q <= div_q + 1'b1;
    end

    // Link clock: toggles on each divider tick, forced low when gated idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !running) sck_q <= 1'b0;
        else if (tick)          sck_q <= ~sck_q;
    end

    // Frame sequencing: load, sample on rise, advance on fall, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            rd_q     <= 1'b0;
            done_q   <= 1'b0;
            bit_q    <= '0;
            sh_q     <= '0;
            rx_q     <= '0;
        end else begin
            done_q <= 1'b0;
            if (ready && start) begin
                active_q <= 1'b1;
                rd_q     <= is_read;
                bit_q    <= '0;
                sh_q     <= {is_read, addr, (is_read ? {DATA_W{1'b0}} : wdata)};
            end else if (active_q && tick) begin
                if (!sck_q) begin
                    if (in_data) rx_q <= {rx_q[DATA_W-2:0], sda_i};
                end else if (bit_q == BW'(FRAME - 1)) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                end else begin
                    bit_q <= bit_q + 1'b1;
                    sh_q  <= {sh_q[FRAME-2:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/pmic_bridge.sv
// PMIC register bus bridge: host register bank, window write queue, split
// read sequencing and the serial frame engine.
// Assumes single-cycle host write strobes and a combinational read path.
module pmic_bridge
    import pmic_bridge_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 16,
    parameter int FIFO_DEPTH = 8,
    parameter int HALF_DIV   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [15:0] host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        link_sck,
    output logic        link_sda_o,
    output logic        link_sda_oe,
    input  logic        link_sda_i
);
    localparam int EW = ADDR_W + DATA_W;
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    logic              mode8_q, clk_on_q, ovf_q;
    logic              rd_pending_q, rd_inflight_q;
    logic [ADDR_W-1:0] rd_req_q, rd_sent_q, rd_echo_q;
    logic [DATA_W-1:0] rd_val_q;

    logic              wr_ctrl0, wr_cfg0, wr_rdcmd, wr_qstat, in_win, push_req;
    logic [EW-1:0]     q_head;
    logic              q_full, q_empty, q_pop;
    logic [CW-1:0]     q_count;
    logic              link_want, link_go, link_ready, link_busy, link_done;
    dir_e              link_dir;
    logic [ADDR_W-1:0] link_addr;
    logic [DATA_W-1:0] link_rdata;
    logic              unused_bits;

    assign unused_bits = ^host_wdata;

    assign wr_ctrl0 = host_wr && (host_addr == OFS_CTRL0);
    assign wr_cfg0  = host_wr && (host_addr == OFS_CFG0);
    assign wr_rdcmd = host_wr && (host_addr == OFS_RDCMD);
    assign wr_qstat = host_wr && (host_addr == OFS_QSTAT);
    assign in_win   = (host_addr >= WIN_BASE) && (host_addr <= WIN_LAST);
    assign push_req = host_wr && in_win;

    function automatic logic [ADDR_W-1:0] shape_addr(input logic narrow,
                                                      input logic [ADDR_W-1:0] a);
        return narrow ? {{(ADDR_W-NARROW_W){1'b0}}, a[NARROW_W-1:0]} : a;
    endfunction

    pmic_bridge_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_req),
        .wdata ({host_addr[ADDR_W-1:0], host_wdata[DATA_W-1:0]}),
        .pop   (q_pop),
        .rdata (q_head),
        .full  (q_full),
        .empty (q_empty),
        .count (q_count)
    );

    // Scheduling: queued writes first, then a pending read that is not yet on the wire.
    assign link_want = !q_empty || (rd_pending_q && !rd_inflight_q);
    assign link_dir  = q_empty ? DIR_READ : DIR_WRITE;
    assign link_addr = shape_addr(mode8_q, q_empty ? rd_req_q : q_head[EW-1:DATA_W]);
    assign link_go   = link_ready && link_want;
    assign q_pop     = link_go && !q_empty;

    pmic_bridge_link #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HALF_DIV(HALF_DIV)) u_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_on  (clk_on_q),
        .start   (link_want),
        .is_read (link_dir == DIR_READ),
        .addr    (link_addr),
        .wdata   (q_head[DATA_W-1:0]),
        .ready   (link_ready),
        .busy    (link_busy),
        .done    (link_done),
        .rdata   (link_rdata),
        .sck     (link_sck),
        .sda_o   (link_sda_o),
        .sda_oe  (link_sda_oe),
        .sda_i   (link_sda_i)
    );

    // Configuration registers: address width and clock gating mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode8_q  <= 1'b0;
            clk_on_q <= 1'b0;
        end else begin
            if (wr_ctrl0) mode8_q  <= host_wdata[0];
            if (wr_cfg0)  clk_on_q <= host_wdata[BIT_CLK_ON];
        end
    end

    // Sticky overflow flag: set by a dropped window write, cleared by writing 1 to it.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ovf_q <= 1'b0;
        else if (push_req && q_full)         ovf_q <= 1'b1;
        else if (wr_qstat && host_wdata[BIT_OVF]) ovf_q <= 1'b0;
    end

    // Split read tracking: accept a command, launch it, capture the reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pending_q  <= 1'b0;
            rd_inflight_q <= 1'b0;
            rd_req_q      <= '0;
            rd_sent_q     <= '0;
            rd_echo_q     <= '0;
            rd_val_q      <= '0;
        end else begin
            if (link_go && link_dir == DIR_READ) begin
                rd_inflight_q <= 1'b1;
                rd_sent_q     <= link_addr;
            end
            if (link_done && rd_inflight_q) begin
                rd_pending_q  <= 1'b0;
                rd_inflight_q <= 1'b0;
                rd_val_q      <= link_rdata;
                rd_echo_q     <= rd_sent_q;
            end
            if (wr_rdcmd && !rd_pending_q) begin
                rd_pending_q <= 1'b1;
                rd_req_q     <= host_wdata[ADDR_W-1:0];
            end
        end
    end

    // Host read mux.
    always_comb begin
        host_rdata = '0;
        case (host_addr)
            OFS_CTRL0:  host_rdata[0] = mode8_q;
            OFS_CFG0:   host_rdata[BIT_CLK_ON] = clk_on_q;
            OFS_RDDATA: begin
                host_rdata[BIT_BUSY]           = rd_pending_q;
                host_rdata[16 +: ADDR_W]       = rd_echo_q;
                host_rdata[DATA_W-1:0]         = rd_val_q;
            end
            OFS_QSTAT: begin
                host_rdata[CW-1:0]     = q_count;
                host_rdata[BIT_EMPTY]  = q_empty;
                host_rdata[BIT_FULL]   = q_full;
                host_rdata[BIT_OVF]    = ovf_q;
            end
            default:    host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pmic_bridge_chk.sv
// Property checker for the PMIC register bus bridge, bound to the top module.
// Assumes the signal names of pmic_bridge listed in the bind below.
module pmic_bridge_chk
    import pmic_bridge_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [15:0]       host_addr,
    input logic              rd_busy,
    input logic [ADDR_W-1:0] rd_req,
    input logic              push_req,
    input logic              q_full,
    input logic              q_empty,
    input logic              ovf,
    input logic              clk_on,
    input logic              link_busy,
    input logic              link_sck,
    input logic              link_sda_o
);
    assert_busy_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == OFS_RDCMD) |=> rd_busy);

    assert_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_full && q_empty));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && q_full) |=> ovf);

    assert_cmd_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_busy && host_wr && host_addr == OFS_RDCMD) |=> $stable(rd_req));

    assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_on && !link_busy) |=> !link_sck);

    assert_data_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        link_sck |-> $stable(link_sda_o));
endmodule

bind pmic_bridge pmic_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .rd_busy    (rd_pending_q),
    .rd_req     (rd_req_q),
    .push_req   (push_req),
    .q_full     (q_full),
    .q_empty    (q_empty),
    .ovf        (ovf_q),
    .clk_on     (clk_on_q),
    .link_busy  (link_busy),
    .link_sck   (link_sck),
    .link_sda_o (link_sda_o)
);

// File: tb/pmic_bridge_tb.sv
module pmic_bridge_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 160;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [15:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        link_sck, link_sda_o, link_sda_oe;
    logic        link_sda_i = 1'b0;

    int checks = 0;
    int failures = 0;

    pmic_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .link_sck(link_sck),
        .link_sda_o(link_sda_o), .link_sda_oe(link_sda_oe), .link_sda_i(link_sda_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] reply(input logic [11:0] a);
        return {a, 4'h3} ^ 16'h5A5A;
    endfunction

    // Slave model: decodes frames on the link and answers reads.
    int          sl_idx = 0;
    logic [28:0] sl_bits = '0;
    logic [15:0] sl_reply = '0;
    logic        log_dir  [64];
    logic [11:0] log_addr [64];
    logic [15:0] log_data [64];
    int          log_n = 0;

    always @(posedge link_sck) begin
        if (!(sl_idx == 0 && !link_sda_oe)) begin
            if (sl_idx < 13 || !sl_bits[28]) sl_bits[28-sl_idx] = link_sda_o;
            if (sl_idx == 12) sl_reply = reply(sl_bits[27:16]);
            sl_idx++;
            if (sl_idx == 29) begin
                if (log_n < 64) begin
                    log_dir[log_n]  = sl_bits[28];
                    log_addr[log_n] = sl_bits[27:16];
                    log_data[log_n] = sl_bits[28] ? sl_reply : sl_bits[15:0];
                    log_n++;
                end
                sl_idx = 0;
            end
        end
    end

    always @(negedge link_sck) begin
        if (sl_idx >= 13 && sl_idx < 29 && sl_bits[28])
            link_sda_i = sl_reply[28 - sl_idx];
    end

    // Data-line stability monitor for the link clock high phase.
    int   viol = 0;
    logic p_sck = 1'b0, p_sda = 1'b0;
    int   sck_edges = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_sck && link_sck && (link_sda_o !== p_sda)) viol++;
            if (!p_sck && link_sck) sck_edges++;
        end
        p_sck = link_sck;
        p_sda = link_sda_o;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [15:0] a, output logic [31:0] v);
        host_addr = a;
        #1 v = host_rdata;
    endtask

    task automatic wait_drain();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            reg_read(16'h0030, s);
            if (s[10]) break;
        end
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic wait_read();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            reg_read(16'h002C, s);
            if (!s[31]) break;
        end
        @(negedge clk);
    endtask

    // Vectors: {host address, write data, expect frame, expected link address}.
    localparam logic [44:0] WR_VEC [6] = '{
        {16'h8000, 16'h1234, 1'b1, 12'h000},
        {16'h8FFE, 16'hBEEF, 1'b1, 12'hFFE},
        {16'h8ABC, 16'h0F0F, 1'b1, 12'hABC},
        {16'h7FFC, 16'h1111, 1'b0, 12'h000},
        {16'h9000, 16'h2222, 1'b0, 12'h000},
        {16'h8004, 16'h8001, 1'b1, 12'h004}
    };

    initial begin
        repeat (400000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        reg_read(16'h002C, v);
        check(v == 32'h0, "R10 rd_data", v, 32'h0);
        reg_read(16'h0030, v);
        check(v == 32'h400, "R10 status", v, 32'h400);
        check(!link_sck && !link_sda_oe, "R10 link idle", {link_sck, link_sda_oe}, 0);

        // R3: table of window and out-of-window writes
        foreach (WR_VEC[k]) begin
            n0 = log_n;
            host_write(WR_VEC[k][44:29], {16'h0, WR_VEC[k][28:13]});
            wait_drain();
            if (WR_VEC[k][12]) begin
                check(log_n == n0 + 1, "R3 frame count", log_n, n0 + 1);
                check(log_dir[n0] == 1'b0 && log_addr[n0] == WR_VEC[k][11:0]
                      && log_data[n0] == WR_VEC[k][28:13], "R3 frame content",
                      {log_dir[n0], log_addr[n0], log_data[n0]},
                      {1'b0, WR_VEC[k][11:0], WR_VEC[k][28:13]});
            end else begin
                check(log_n == n0, "R3 outside window", log_n, n0);
            end
        end

        // R4 R5: fill the queue, overflow, order, sticky flag and clear
        n0 = log_n;
        for (int i = 1; i <= 9; i++) host_write(16'h8000 + 16'(2*i), 32'(i));
        @(negedge clk); reg_read(16'h0030, v);
        check(v == 32'h808, "R4 full count", v, 32'h808);
        host_write(16'h8040, 32'hDEAD);
        @(negedge clk); reg_read(16'h0030, v);
        check(v == 32'h1808, "R5 overflow set", v, 32'h1808);
        wait_drain();
        check(log_n == n0 + 9, "R5 dropped write", log_n, n0 + 9);
        for (int i = 0; i < 9; i++)
            check(log_data[n0+i] == 16'(i+1), "R3 order", log_data[n0+i], i + 1);
        reg_read(16'h0030, v);
        check(v == 32'h1400, "R5 sticky after drain", v, 32'h1400);
        host_write(16'h0030, 32'h1000);
        @(negedge clk); reg_read(16'h0030, v);
        check(v == 32'h400, "R5 cleared", v, 32'h400);

        // R1 R2 R7: read, busy, echo, ignored second command
        n0 = log_n;
        host_write(16'h0028, 32'h5BC5);
        reg_read(16'h002C, v);
        check(v[31] == 1'b1, "R1 busy", v[31], 1);
        host_write(16'h0028, 32'h0111);
        wait_read();
        reg_read(16'h002C, v);
        check(v == {16'h0BC5, reply(12'hBC5)}, "R2 read data", v, {16'h0BC5, reply(12'hBC5)});
        repeat (SETTLE) @(negedge clk);
        check(log_n == n0 + 1, "R7 single frame", log_n, n0 + 1);
        check(log_dir[n0] == 1'b1 && log_addr[n0] == 12'hBC5, "R2 read frame",
              {log_dir[n0], log_addr[n0]}, {1'b1, 12'hBC5});

        // R6: read behind queued writes
        n0 = log_n;
        host_write(16'h8010, 32'hA1);
        host_write(16'h8012, 32'hA2);
        host_write(16'h8014, 32'hA3);
        host_write(16'h0028, 32'h0222);
        wait_read();
        repeat (SETTLE) @(negedge clk);
        check(log_n == n0 + 4 && !log_dir[n0] && !log_dir[n0+1] && !log_dir[n0+2]
              && log_dir[n0+3], "R6 order", {log_dir[n0], log_dir[n0+1], log_dir[n0+2],
              log_dir[n0+3]}, 4'b0001);
        reg_read(16'h002C, v);
        check(v == {16'h0222, reply(12'h222)}, "R6 read data", v, {16'h0222, reply(12'h222)});

        // R8: 8-bit addressing
        host_write(16'h0004, 32'h1);
        n0 = log_n;
        host_write(16'h0028, 32'h0ABC);
        wait_read();
        reg_read(16'h002C, v);
        check(v == {16'h00BC, reply(12'h0BC)}, "R8 echo", v, {16'h00BC, reply(12'h0BC)});
        host_write(16'h8F12, 32'h7777);
        wait_drain();
        check(log_addr[n0] == 12'h0BC && log_addr[n0+1] == 12'h012, "R8 link address",
              {log_addr[n0], log_addr[n0+1]}, {12'h0BC, 12'h012});
        host_write(16'h0004, 32'h0);

        // R9: free-running versus gated idle clock
        host_write(16'h0020, 32'h4000_0000);
        n0 = sck_edges;
        repeat (100) @(negedge clk);
        check(sck_edges > n0, "R9 free running", sck_edges - n0, 1);
        n0 = log_n;
        host_write(16'h8006, 32'h3C3C);
        wait_drain();
        check(log_n == n0 + 1 && log_data[n0] == 16'h3C3C, "R9 frame with clock on",
              log_data[n0], 16'h3C3C);
        host_write(16'h0020, 32'h0);
        repeat (10) @(negedge clk);
        n0 = sck_edges;
        repeat (100) @(negedge clk);
        check(sck_edges == n0 && !link_sck, "R9 gated idle", sck_edges - n0, 0);

        // R11: data line stable while the link clock is high
        check(viol == 0, "R11 data stability", viol, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule